// File: doc/BRIEF.md
# Maskable Bit-Condition Interrupt Monitor

This block watches the eight lines of a port whose pins are programmed bit by bit. It raises an interrupt request when a chosen logic condition holds on the lines that are not masked out. A configuration port loads three things: a per-line mask, a condition byte, and a master enable. The condition byte picks the active level of the lines and whether the monitored lines are combined with AND or with OR. The interrupt status follows the condition at every clock. The request output is active low and only ever pulls low or lets go, so several sources can share one wire.

The line inputs are asynchronous to the clock. They pass through a two-stage synchronizer before the condition is evaluated. A master enable gates the request pin and leaves the status bit alone, so software can poll the status with the pin disabled. While any configuration write strobe is high, the request is held inactive. This stops a half-loaded setup from firing a false interrupt. A mask with every line excluded would never match anything, so a write of that pattern is refused.

Top module: `bitcond_irq_mon`

## Requirements
- R1: After reset (`rst_n` low, asynchronous) the mask is 0x00, the enable is off, the condition is level high with OR combination, `int_status` is 0 and `irq_n` is 1.
- R2: Mask bit i = 1 removes line i from the condition. Mask bit i = 0 includes it.
- R3: A mask write with `mask_wdata` = 0xFF is ignored, and the previous mask stays in force.
- R4: With `cond_wdata[1]` = 0 (OR), the status is 1 when at least one monitored line equals the active level.
- R5: With `cond_wdata[1]` = 1 (AND), the status is 1 only when every monitored line equals the active level.
- R6: `cond_wdata[0]` selects the active level: 1 means a line matches when high, 0 means it matches when low.
- R7: A line change applied before clock edge k shows on `int_status` after edge k+2: two synchronizer stages, then the status register. A configuration write at edge k is used in the evaluation at edge k+1.
- R8: `irq_n` is 0 exactly when the status is 1, the enable is on, and none of `mask_we`, `cond_we` or `en_we` is high. The enable has no effect on `int_status`.
- R9: A high `clr` at a clock edge gives the same state as reset: mask 0x00, enable off, default condition, and status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear to the reset state |
| lines | input | 8 | Asynchronous port line values |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask value; 1 excludes a line; 0xFF is refused |
| cond_we | input | 1 | Condition write strobe |
| cond_wdata | input | 2 | Bit 0 active level (1 high), bit 1 combine (1 AND, 0 OR) |
| en_we | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Master interrupt enable value |
| irq_n | output | 1 | Interrupt request, active low; 1 means released |
| int_status | output | 1 | Interrupt status, readable whatever the enable is |

## Verification
On every cycle, the checker confirms four properties. The mask never holds all ones. A refused write leaves the mask unchanged. A pulled-low request always has a set status behind it and never occurs during a configuration write. A clear returns the state to its reset values. The synchronizer latency, the AND and OR evaluation under both active levels, and the masking of individual lines can only be shown by the bench. It compares a behavioural model with the outputs at every clock, over directed scenarios and a stretch of random stimulus.

// File: rtl/bitcond_pkg.sv
package bitcond_pkg;
  localparam int LINE_W = 8;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic and_mode;  // 1: all monitored lines must match
    logic level;     // 1: a line matches when high
  } cond_t;

  localparam int COND_W = $bits(cond_t);
  localparam cond_t COND_RESET = '{and_mode: 1'b0, level: 1'b1};
endpackage

// File: rtl/bitcond_sync.sv
module bitcond_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (clr) begin
          stage_q[s] <= '0;
        end else begin
          if (s == 0) stage_q[s] <= d;
          else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bitcond_cfg.sv
module bitcond_cfg
  import bitcond_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic         cond_we,
  input  cond_t        cond_wdata,
  input  logic         en_we,
  input  logic         en_wdata,
  output logic [W-1:0] mask_q,
  output cond_t        cond_q,
  output logic         en_q
);
  localparam logic [W-1:0] ALL_MASKED = '1;

  logic mask_accept;
  assign mask_accept = mask_we && (mask_wdata != ALL_MASKED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      cond_q <= COND_RESET;
      en_q   <= 1'b0;
    end else if (clr) begin
      mask_q <= '0;
      cond_q <= COND_RESET;
      en_q   <= 1'b0;
    end else begin
      if (mask_accept) mask_q <= mask_wdata;
      if (cond_we)     cond_q <= cond_wdata;
      if (en_we)       en_q   <= en_wdata;
    end
  end
endmodule

// File: rtl/bitcond_eval.sv
module bitcond_eval
  import bitcond_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] lines_s,
  input  logic [W-1:0] mask,
  input  cond_t        cond,
  output logic         hit
);
  logic [W-1:0] match;

  generate
    for (genvar i = 0; i < W; i++) begin : g_line
      assign match[i] = (lines_s[i] == cond.level);
    end
  endgenerate

  logic all_hit, any_hit;
  assign all_hit = &(match | mask);
  assign any_hit = |(match & ~mask);
  assign hit     = cond.and_mode ? all_hit : any_hit;
endmodule

// File: rtl/bitcond_irq_mon.sv
module bitcond_irq_mon
  import bitcond_pkg::*;
#(
  parameter int W = LINE_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] lines,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic         cond_we,
  input  logic [1:0]   cond_wdata,
  input  logic         en_we,
  input  logic         en_wdata,
  output logic         irq_n,
  output logic         int_status
);
  logic [W-1:0] lines_s;
  logic [W-1:0] mask_q;
  cond_t        cond_q;
  logic         en_q;
  logic         hit;
  logic         status_q;
  logic         cfg_busy;

  bitcond_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(clr), .d(lines), .q(lines_s)
  );

  bitcond_cfg #(.W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .cond_we(cond_we), .cond_wdata(cond_t'(cond_wdata)),
    .en_we(en_we), .en_wdata(en_wdata),
    .mask_q(mask_q), .cond_q(cond_q), .en_q(en_q)
  );

  bitcond_eval #(.W(W)) u_eval (
    .lines_s(lines_s), .mask(mask_q), .cond(cond_q), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status_q <= 1'b0;
    else if (clr) status_q <= 1'b0;
    else          status_q <= hit;
  end

  assign cfg_busy   = mask_we | cond_we | en_we;
  assign int_status = status_q;
  assign irq_n      = ~(status_q & en_q & ~cfg_busy);
endmodule

// File: rtl/bitcond_irq_mon_chk.sv
module bitcond_irq_mon_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         mask_we,
  input logic [W-1:0] mask_wdata,
  input logic         cond_we,
  input logic         en_we,
  input logic [W-1:0] mask_q,
  input logic         irq_n,
  input logic         int_status
);
  // R3
  mask_never_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q != '1);

  // R3
  mask_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && mask_wdata == '1 && !clr) |=> $stable(mask_q));

  // R8
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> int_status);

  // R8
  irq_quiet_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we || cond_we || en_we) |-> irq_n);

  // R9
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!int_status && mask_q == '0));
endmodule

bind bitcond_irq_mon bitcond_irq_mon_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr),
  .mask_we(mask_we), .mask_wdata(mask_wdata),
  .cond_we(cond_we), .en_we(en_we),
  .mask_q(mask_q), .irq_n(irq_n), .int_status(int_status)
);

// File: tb/bitcond_irq_mon_test.sv
module bitcond_irq_mon_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] lines = 8'h00;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = 8'h00;
  logic       cond_we = 1'b0;
  logic [1:0] cond_wdata = 2'b00;
  logic       en_we = 1'b0;
  logic       en_wdata = 1'b0;
  logic       irq_n;
  logic       int_status;

  bitcond_irq_mon uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .lines(lines),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .cond_we(cond_we), .cond_wdata(cond_wdata),
    .en_we(en_we), .en_wdata(en_wdata),
    .irq_n(irq_n), .int_status(int_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [7:0] m_mask = 8'h00;
  bit m_level = 1, m_and = 0, m_en = 0, m_status = 0;
  logic [7:0] hist[$];  // line samples still inside the synchronizer

  function automatic bit ref_cond(logic [7:0] v, logic [7:0] mk, bit lvl, bit all);
    int matched = 0, watched = 0;
    for (int i = 0; i < 8; i++) begin
      if (!mk[i]) begin
        watched++;
        if (v[i] == lvl) matched++;
      end
    end
    return all ? (matched == watched) : (matched > 0);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    if (!rst_n || clr) begin
      m_mask = 8'h00; m_level = 1; m_and = 0; m_en = 0; m_status = 0;
      hist = '{8'h00, 8'h00};
    end else begin
      m_status = ref_cond(hist[0], m_mask, m_level, m_and);
      void'(hist.pop_front());
      hist.push_back(lines);
      if (mask_we && mask_wdata != 8'hFF) m_mask = mask_wdata;
      if (cond_we) begin m_level = cond_wdata[0]; m_and = cond_wdata[1]; end
      if (en_we) m_en = en_wdata;
    end
  endtask

  task automatic tick();
    bit exp_irq_n;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cycles++;
    exp_irq_n = !(m_status && m_en && !(mask_we || cond_we || en_we));
    check(int_status == m_status, cur_req, "int_status", int_status, m_status);
    check(irq_n == exp_irq_n, cur_req, "irq_n", irq_n, exp_irq_n);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr_mask(logic [7:0] v);
    mask_we = 1; mask_wdata = v; tick(); mask_we = 0;
  endtask

  task automatic wr_cond(bit all, bit lvl);
    cond_we = 1; cond_wdata = {all, lvl}; tick(); cond_we = 0;
  endtask

  task automatic wr_en(bit v);
    en_we = 1; en_wdata = v; tick(); en_we = 0;
  endtask

  initial begin
    while (!done && cycles < WATCHDOG) @(negedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    hist = '{8'h00, 8'h00};
    // R1 reset state
    cur_req = "R1";
    idle(3);
    check(int_status == 0, "R1", "status after reset", int_status, 0);
    check(irq_n == 1, "R1", "irq_n after reset", irq_n, 1);
    rst_n = 1;
    idle(3);

    // R7 latency in OR mode, level high
    cur_req = "R7";
    wr_en(1);
    lines = 8'h10;
    tick(); check(int_status == 0, "R7", "status 1 edge", int_status, 0);
    tick(); check(int_status == 0, "R7", "status 2 edges", int_status, 0);
    tick(); check(int_status == 1, "R7", "status 3 edges", int_status, 1);
    check(irq_n == 0, "R8", "irq_n asserted", irq_n, 0);

    // R2 masked line ignored
    cur_req = "R2";
    wr_mask(8'h10);
    idle(3);
    check(int_status == 0, "R2", "masked line4 high", int_status, 0);
    lines = 8'h11; idle(3);
    check(int_status == 1, "R2", "unmasked line0 high", int_status, 1);

    // R3 all-ones mask refused
    cur_req = "R3";
    wr_mask(8'hFF);
    idle(2);
    check(int_status == 1, "R3", "status after refused mask", int_status, 1);
    lines = 8'h10; idle(3);
    check(int_status == 0, "R3", "old mask still active", int_status, 0);

    // R5 AND mode
    cur_req = "R5";
    wr_mask(8'hF0); wr_cond(1, 1);
    lines = 8'h0F; idle(3);
    check(int_status == 1, "R5", "all monitored high", int_status, 1);
    lines = 8'h0E; idle(3);
    check(int_status == 0, "R5", "one monitored low", int_status, 0);

    // R6 level low, R4 OR
    cur_req = "R6";
    wr_cond(0, 0);
    lines = 8'hFF; idle(3);
    check(int_status == 0, "R6", "no line low", int_status, 0);
    lines = 8'hFE; idle(3);
    check(int_status == 1, "R4", "one low line under OR", int_status, 1);

    // R8 enable gates the pin, not the status; write strobes silence it
    cur_req = "R8";
    wr_en(0); tick();
    check(int_status == 1 && irq_n == 1, "R8", "disabled pin", {int_status, irq_n}, 2'b11);
    wr_en(1);
    mask_we = 1; mask_wdata = 8'hF0; @(negedge clk);
    check(irq_n == 1, "R8", "irq_n during write", irq_n, 1);
    tick(); mask_we = 0; tick();
    check(irq_n == 0, "R8", "irq_n after write", irq_n, 0);

    // R9 synchronous clear
    cur_req = "R9";
    clr = 1; tick(); clr = 0; tick();
    check(int_status == 0 && irq_n == 1, "R9", "after clear", {int_status, irq_n}, 2'b01);
    lines = 8'h01; idle(3);
    check(int_status == 1, "R9", "default cond after clear", int_status, 1);

    // random stretch against the model
    cur_req = "R4";
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 15);
      lines = 8'($urandom);
      if (r == 0) wr_mask(8'($urandom) | (($urandom_range(0, 3) == 0) ? 8'hFF : 8'h00));
      else if (r == 1) wr_cond(1'($urandom), 1'($urandom));
      else if (r == 2) wr_en(1'($urandom));
      else if (r == 3) begin clr = 1; tick(); clr = 0; end
      else tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule